// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a memory-mapped watchdog built around an up-counter that advances once per qualifying tick. Software stores a limit value and sets a run bit. It also picks one of two actions for the moment the count equals the limit: a level interrupt, or a one-cycle request for a system reset. When the count reaches the limit it stops there and does not wrap, so each service interval produces exactly one event. Software services the watchdog by writing the clear register, which returns the count to zero.

A sticky cause flag records that the watchdog requested a reset. The flag is clocked from the power-on reset only, so it keeps its value through the system reset that the watchdog itself triggers. Boot code can therefore read why the chip restarted and then clear the flag by writing a 1 to it. The register bus is a plain single-cycle port. A write takes effect on the clock edge where `wr_en` is high, and reads are combinational from `addr`. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `wdt_match_top`

## Requirements
- R1: After power-on reset, or after a system reset with `por_n` high, the control register reads 0, the limit register reads 0xFFFF, the count reads 0, and `irq` and `rst_req` are low. The cause flag also reads 0 after power-on reset.
- R2: While run (control bit 0) is 1, the count rises by exactly one on each clock edge where `tick_en` is 1. It holds when run is 0 or `tick_en` is 0.
- R3: Writing a value with bit 0 set to the clear offset 0x0C zeroes the count on that edge, and this takes priority over a tick. A write to that offset with bit 0 clear has no effect.
- R4: A match exists while run is 1 and the count equals the limit (offset 0x04, 16 bits). During a match, further ticks leave the count at the limit.
- R5: With response select (control bit 1) equal to 0, `irq` is high exactly while a match exists. It falls once the count is cleared or run is written to 0.
- R6: With response select equal to 1, `rst_req` is high for exactly one cycle. That cycle starts at the first clock edge after the match begins, and a match never produces a second pulse. `irq` stays low in this mode.
- R7: The cause flag (offset 0x10, bit 0) is set on the same edge that raises `rst_req`. It survives `rst_n`. Only `por_n` low, or a write with bit 0 set to offset 0x10, clears it.
- R8: The register map is: control 0x00, limit 0x04, count 0x08 (read-only), clear 0x0C (write-only) and cause 0x10. Reads of the clear offset or of an unmapped offset return 0, and writes to the count offset are ignored.
- R9: Control bits 1:0 read back as written, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears all state except the cause flag |
| tick_en | input | 1 | Count-enable tick, one cycle per timer period |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Match interrupt level (response select 0) |
| rst_req | output | 1 | One-cycle reset request (response select 1) |

## Verification
The assertions assume that `tick_en` and the bus inputs are synchronous to `clk`, and that the response select bit is not changed while a match is already in progress. They also assume the limit is not lowered below the current count while the counter is running, because the count would then wrap through 0xFFFF before it matched. The stimulus writes control and limit only after clearing the count. It keeps limits between 1 and 12 during the random phase, and it injects clear writes at random so that clears also land during matches and on tick edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    RESP_IRQ   = 1'b0,
    RESP_RESET = 1'b1
  } wdt_resp_e;

  typedef struct packed {
    wdt_resp_e resp;
    logic      run;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);

  typedef struct packed {
    logic ctrl_wr;
    logic limit_wr;
    logic cnt_clr;
    logic cause_w1c;
  } wdt_wr_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter logic [AW-1:0] OFS_CTRL  = 8'h00,
  parameter logic [AW-1:0] OFS_LIMIT = 8'h04,
  parameter logic [AW-1:0] OFS_COUNT = 8'h08,
  parameter logic [AW-1:0] OFS_CLEAR = 8'h0C,
  parameter logic [AW-1:0] OFS_CAUSE = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] count,
  input  logic          cause,
  output wdt_ctrl_t     ctrl,
  output logic [CW-1:0] limit,
  output wdt_wr_t       wr,
  output logic [DW-1:0] rd_data
);
  localparam logic [CW-1:0] LIMIT_RST = {CW{1'b1}};

  always_comb begin
    wr.ctrl_wr   = wr_en && (addr == OFS_CTRL);
    wr.limit_wr  = wr_en && (addr == OFS_LIMIT);
    wr.cnt_clr   = wr_en && (addr == OFS_CLEAR) && wdata[0];
    wr.cause_w1c = wr_en && (addr == OFS_CAUSE) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      limit <= LIMIT_RST;
    end else begin
      if (wr.ctrl_wr)  ctrl  <= wdt_ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr.limit_wr) limit <= wdata[CW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_CTRL:  rd_data = {{(DW-CTRL_W){1'b0}}, ctrl};
      OFS_LIMIT: rd_data = {{(DW-CW){1'b0}}, limit};
      OFS_COUNT: rd_data = {{(DW-CW){1'b0}}, count};
      OFS_CAUSE: rd_data = {{(DW-1){1'b0}}, cause};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          hit
);
  logic at_limit;

  assign at_limit = (count == limit);
  assign hit      = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (run && tick_en && !at_limit) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_response.sv
module wdt_response
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  wdt_resp_e resp,
  output logic      irq,
  output logic      rst_req,
  output logic      fire
);
  logic hit_seen_q;

  assign irq  = hit && (resp == RESP_IRQ);
  assign fire = hit && !hit_seen_q && (resp == RESP_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_seen_q <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      hit_seen_q <= hit;
      rst_req    <= fire;
    end
  end
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic cause
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cause <= 1'b0;
    else if (set) cause <= 1'b1;
    else if (clr) cause <= 1'b0;
  end
endmodule

// File: rtl/wdt_match_top.sv
module wdt_match_top
  import wdt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          rst_req
);
  logic          sys_rst_n;
  wdt_ctrl_t     ctrl;
  wdt_wr_t       wr;
  logic [CW-1:0] limit;
  logic [CW-1:0] count;
  logic          hit;
  logic          fire;
  logic          cause;
  logic          run_w;

  assign sys_rst_n = rst_n && por_n;
  assign run_w     = ctrl.run;

  wdt_regs #(.AW(AW), .DW(DW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(sys_rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .count(count), .cause(cause), .ctrl(ctrl), .limit(limit), .wr(wr),
    .rd_data(rd_data)
  );

  wdt_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(sys_rst_n), .tick_en(tick_en), .run(run_w),
    .clr(wr.cnt_clr), .limit(limit), .count(count), .hit(hit)
  );

  wdt_response resp_i (
    .clk(clk), .rst_n(sys_rst_n), .hit(hit), .resp(ctrl.resp),
    .irq(irq), .rst_req(rst_req), .fire(fire)
  );

  wdt_cause cause_i (
    .clk(clk), .por_n(por_n), .set(fire), .clr(wr.cause_w1c), .cause(cause)
  );
endmodule

// File: rtl/wdt_match_chk.sv
module wdt_match_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          sys_rst_n,
  input logic          por_n,
  input logic          irq,
  input logic          rst_req,
  input logic [CW-1:0] count,
  input logic          run,
  input logic          hit,
  input logic          clr,
  input logic          ctrl_wr,
  input logic          limit_wr,
  input logic          cause,
  input logic          cause_w1c
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !clr |=> (count == $past(count)) || (count == CW'($past(count) + 1'b1)));

  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    clr |=> (count == '0));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (hit && !clr) |=> $stable(count));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (irq && !clr && !ctrl_wr && !limit_wr) |=> irq);

  assert_irq_needs_run_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    irq |-> run);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |=> !rst_req);

  assert_cause_on_req_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |-> cause);

  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cause && !cause_w1c) |=> cause);
endmodule

bind wdt_match_top wdt_match_chk #(.CW(CW)) chk_i (
  .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n), .irq(irq), .rst_req(rst_req),
  .count(count), .run(run_w), .hit(hit), .clr(wr.cnt_clr), .ctrl_wr(wr.ctrl_wr),
  .limit_wr(wr.limit_wr), .cause(cause), .cause_w1c(wr.cause_w1c)
);

// File: tb/wdt_match_top_tb.sv
module wdt_match_top_tb_top;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_LIMIT = 8'h04;
  localparam logic [7:0] A_COUNT = 8'h08;
  localparam logic [7:0] A_CLEAR = 8'h0C;
  localparam logic [7:0] A_CAUSE = 8'h10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_match_top dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_req) pulses++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; wr_en = 1'b0;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] c, input logic [15:0] lim,
                                             input bit run, input bit tk, input bit clr);
    if (clr) return 16'h0;
    if (run && tk && c != lim) return c + 16'h1;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] mc;
    logic [15:0] lim;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    bus_rd(A_CTRL, v);  check("R1 ctrl", v, 0);
    bus_rd(A_LIMIT, v); check("R1 limit", v, 32'hFFFF);
    bus_rd(A_COUNT, v); check("R1 count", v, 0);
    bus_rd(A_CAUSE, v); check("R1 cause", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);

    // R8 map corners
    bus_wr(A_COUNT, 32'h1234);
    bus_rd(A_COUNT, v); check("R8 count write ignored", v, 0);
    bus_rd(A_CLEAR, v); check("R8 clear reads zero", v, 0);
    bus_rd(8'h3C, v);   check("R8 unmapped reads zero", v, 0);

    // R2 / R9
    bus_wr(A_LIMIT, 100);
    bus_wr(A_CTRL, 32'hFFFF_FFFD);
    bus_rd(A_CTRL, v); check("R9 ctrl readback", v, 1);
    ticks(5);
    bus_rd(A_COUNT, v); check("R2 five ticks", v, 5);
    repeat (3) @(negedge clk);
    bus_rd(A_COUNT, v); check("R2 hold no tick", v, 5);
    bus_wr(A_CTRL, 0);
    ticks(4);
    bus_rd(A_COUNT, v); check("R2 hold run off", v, 5);

    // R3
    bus_wr(A_CLEAR, 32'hFFFF_FFFE);
    bus_rd(A_COUNT, v); check("R3 clear bit0 zero no effect", v, 5);
    bus_wr(A_CTRL, 1);
    tick_en = 1'b1;
    bus_wr(A_CLEAR, 1);
    tick_en = 1'b0;
    bus_rd(A_COUNT, v); check("R3 clear beats tick", v, 0);

    // R4 / R5 interrupt mode
    bus_wr(A_LIMIT, 8);
    ticks(20);
    bus_rd(A_COUNT, v); check("R4 stops at limit", v, 8);
    check("R5 irq on match", {31'b0, irq}, 1);
    check("R6 no pulse in irq mode", {31'b0, rst_req}, 0);
    repeat (4) @(negedge clk);
    check("R5 irq level holds", {31'b0, irq}, 1);
    bus_wr(A_CLEAR, 1);
    check("R5 irq drops on clear", {31'b0, irq}, 0);
    ticks(8);
    check("R5 irq again", {31'b0, irq}, 1);
    bus_wr(A_CTRL, 0);
    check("R5 irq drops on run off", {31'b0, irq}, 0);

    // R6 / R7 reset mode
    bus_wr(A_CLEAR, 1);
    bus_wr(A_LIMIT, 3);
    pulses = 0;
    bus_wr(A_CTRL, 3);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(A_COUNT, v); check("R4 reached limit 3", v, 3);
    check("R6 no pulse same cycle", {31'b0, rst_req}, 0);
    check("R6 irq low in reset mode", {31'b0, irq}, 0);
    @(negedge clk);
    check("R6 pulse next cycle", {31'b0, rst_req}, 1);
    bus_rd(A_CAUSE, v); check("R7 cause set with pulse", v, 1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, rst_req}, 0);
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    check("R6 single pulse per match", pulses, 1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(A_CAUSE, v); check("R7 cause survives rst_n", v, 1);
    bus_rd(A_CTRL, v);  check("R1 ctrl after rst_n", v, 0);
    bus_rd(A_COUNT, v); check("R1 count after rst_n", v, 0);
    bus_wr(A_CAUSE, 0);
    bus_rd(A_CAUSE, v); check("R7 write zero keeps cause", v, 1);
    bus_wr(A_CAUSE, 1);
    bus_rd(A_CAUSE, v); check("R7 w1c clears cause", v, 0);

    bus_wr(A_LIMIT, 2);
    bus_wr(A_CTRL, 3);
    ticks(4);
    bus_rd(A_CAUSE, v); check("R7 cause set again", v, 1);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    bus_rd(A_CAUSE, v); check("R7 por clears cause", v, 0);

    // Random phase, interrupt mode (R2 R3 R4 R5)
    lim = 16'($urandom_range(12, 1));
    bus_wr(A_LIMIT, {16'h0, lim});
    bus_wr(A_CTRL, 1);
    mc = 0;
    for (int i = 0; i < 400; i++) begin
      bit tk;
      bit cl;
      bus_rd(A_COUNT, v);
      check("R2 random count", v, {16'h0, mc});
      check("R5 random irq", {31'b0, irq}, {31'b0, (mc == lim)});
      tk = ($urandom_range(3, 0) != 0);
      cl = ($urandom_range(15, 0) == 0);
      tick_en = tk;
      if (cl) begin addr = A_CLEAR; wdata = 1; wr_en = 1'b1; end
      mc = model_next(mc, lim, 1'b1, tk, cl);
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
    end

    done = 1'b1;
    summary();
  end
endmodule